// File: doc/BRIEF.md
# NAND Program Command Sequencer

This block is a host-side engine that writes pages into a parallel NAND flash device. The host hands it one step at a time. A step can open a page at a given row and column, send one data byte, move the column pointer inside the open page, or close the page. A page can be closed with a normal program confirm or with a cache-program confirm. For each step the block drives the command-latch, address-latch, write-enable, read-enable and chip-enable strobes and the 8-bit output bus.

After a confirm byte, the block waits a programmable settle time before it trusts the ready/busy line. It then waits for that line to go high. Next it issues the status command and reads the status byte as many times as needed, until the bit that belongs to the step is set:

- After a cache confirm, the block waits on bit 6 (cache ready).
- After a final confirm, the block waits on bit 5 (array ready).

Every step ends with a one-cycle done pulse. For a final confirm, that pulse also carries a fail flag, taken from status bit 0.

Top module: `nand_prog_seq`

## Requirements
- R1: After reset, ready is 1, nand_ce_n, nand_we_n and nand_re_n are 1, and nand_cle, nand_ale, nand_io_oe and done are 0.
- R2: Operation code 0 (open) sends the following bytes in this order:
  - command byte 80h, with cle=1 and ale=0;
  - five address bytes with ale=1 and cle=0, in the order col[7:0], col[15:8], row[7:0], row[15:8], row[23:16].
  - cle and ale are never both 1.
- R3: Operation code 1 (data) sends req_data as one byte with cle=0 and ale=0.
- R4: Operation code 2 (column change) sends command byte 85h, then col[7:0] and col[15:8] as address bytes. It may be repeated any number of times inside one open page.
- R5: Operation code 3 (final confirm) proceeds as follows:
  - It sends command 10h.
  - It waits for ready/busy, then sends command 70h.
  - It reads status until bit 5 is 1.
  - It then pulses done with fail equal to status bit 0. fail is never 1 without done.
- R6: Operation code 4 (cache confirm) sends command 15h. After the status command, it reads status until bit 6 is 1, then pulses done with fail=0, even while bit 5 is still 0.
- R7: After any confirm byte, nand_rb is ignored for SETTLE cycles. Command 70h is therefore never issued while the device has not yet lowered ready/busy.
- R8: Each written byte is held while nand_we_n is low for exactly one cycle. The byte is taken on the rising edge of nand_we_n. nand_io_oe is 0 whenever nand_re_n is low.
- R9: nand_ce_n stays low from the open step until the done of a final confirm, including the idle gaps between steps. It is low during every strobe.
- R10: req_valid is ignored while ready is 0. No byte from such a request reaches the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Step request, taken when ready is 1 |
| req_op | input | 3 | 0 open, 1 data, 2 column change, 3 final confirm, 4 cache confirm |
| req_col | input | 16 | Column address |
| req_row | input | 24 | Row address |
| req_data | input | 8 | Data byte |
| ready | output | 1 | Idle, able to take a step |
| done | output | 1 | One-cycle end-of-step pulse |
| fail | output | 1 | Program failure, valid with done |
| status | output | 8 | Last status byte read |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_io_out | output | 8 | Byte driven to the device |
| nand_io_oe | output | 1 | Output enable for nand_io_out |
| nand_io_in | input | 8 | Byte from the device |
| nand_rb | input | 1 | Ready/busy, high when ready |

## Verification
The assertions assume the following about the device side:

- The host raises req_valid only with an operation code from 0 to 4.
- The device lowers ready/busy within SETTLE cycles of a confirm byte.
- The device keeps the status byte on nand_io_in stable while read-enable is low.

The bench's device model meets these assumptions. It drops ready/busy two cycles after a confirm, which is shorter than the settle time. It drives a status byte built from its own busy timers. The bench issues steps only after it has seen ready, except in the one scenario that deliberately sends a request while the block is busy.

// File: rtl/nand_prog_seq.sv
module nand_prog_seq #(
  parameter int SETTLE = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [2:0]  req_op,
  input  logic [15:0] req_col,
  input  logic [23:0] req_row,
  input  logic [7:0]  req_data,
  output logic        ready,
  output logic        done,
  output logic        fail,
  output logic [7:0]  status,
  output logic        nand_ce_n,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_we_n,
  output logic        nand_re_n,
  output logic [7:0]  nand_io_out,
  output logic        nand_io_oe,
  input  logic [7:0]  nand_io_in,
  input  logic        nand_rb
);
  localparam int CW = $clog2(SETTLE + 1);
  localparam logic [CW-1:0] SET_LAST = CW'(SETTLE - 1);
  localparam logic [2:0] OP_OPEN = 3'd0, OP_DATA = 3'd1, OP_COL = 3'd2,
                         OP_PROG = 3'd3, OP_CACHE = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_SEND, S_SETTLE, S_WAITRB, S_CMD70, S_READ, S_DONE} st_t;

  st_t         st;
  logic        ph, sess;
  logic [2:0]  idx, op, last_idx;
  logic [15:0] col;
  logic [23:0] row;
  logic [7:0]  dat, wbyte;
  logic [CW-1:0] cnt;
  logic        wcle, wale, poll_hit;

  assign last_idx = (op == OP_OPEN) ? 3'd5 : (op == OP_COL) ? 3'd2 : 3'd0;
  assign poll_hit = (op == OP_CACHE) ? nand_io_in[6] : nand_io_in[5];

  always_comb begin
    wbyte = dat;
    wcle  = 1'b0;
    wale  = 1'b0;
    if (st == S_CMD70) begin
      wbyte = 8'h70;
      wcle  = 1'b1;
    end else begin
      case (op)
        OP_OPEN: begin
          wcle = (idx == 3'd0);
          wale = (idx != 3'd0);
          case (idx)
            3'd0:    wbyte = 8'h80;
            3'd1:    wbyte = col[7:0];
            3'd2:    wbyte = col[15:8];
            3'd3:    wbyte = row[7:0];
            3'd4:    wbyte = row[15:8];
            default: wbyte = row[23:16];
          endcase
        end
        OP_COL: begin
          wcle = (idx == 3'd0);
          wale = (idx != 3'd0);
          case (idx)
            3'd0:    wbyte = 8'h85;
            3'd1:    wbyte = col[7:0];
            default: wbyte = col[15:8];
          endcase
        end
        OP_PROG:  begin wbyte = 8'h10; wcle = 1'b1; end
        OP_CACHE: begin wbyte = 8'h15; wcle = 1'b1; end
        default:  ;
      endcase
    end
  end

  wire writing = (st == S_SEND) || (st == S_CMD70);

  assign ready       = (st == S_IDLE);
  assign done        = (st == S_DONE);
  assign fail        = done && (op == OP_PROG) && status[0];
  assign nand_ce_n   = !(sess || !ready);
  assign nand_cle    = writing && wcle;
  assign nand_ale    = writing && wale;
  assign nand_io_out = writing ? wbyte : 8'h00;
  assign nand_io_oe  = writing;
  assign nand_we_n   = !(writing && !ph);
  assign nand_re_n   = !(st == S_READ && !ph);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= 1'b0; sess <= 1'b0; idx <= '0; op <= '0;
      col <= '0; row <= '0; dat <= '0; cnt <= '0; status <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid && req_op <= OP_CACHE) begin
          op <= req_op; col <= req_col; row <= req_row; dat <= req_data;
          idx <= '0; ph <= 1'b0; st <= S_SEND;
          if (req_op == OP_OPEN) sess <= 1'b1;
        end
        S_SEND: begin
          ph <= !ph;
          if (ph) begin
            if (idx != last_idx) idx <= idx + 3'd1;
            else if (op == OP_PROG || op == OP_CACHE) begin st <= S_SETTLE; cnt <= '0; end
            else st <= S_DONE;
          end
        end
        S_SETTLE: begin
          cnt <= cnt + 1'b1;
          if (cnt == SET_LAST) st <= S_WAITRB;
        end
        S_WAITRB: if (nand_rb) begin st <= S_CMD70; ph <= 1'b0; end
        S_CMD70: begin
          ph <= !ph;
          if (ph) st <= S_READ;
        end
        S_READ: begin
          ph <= !ph;
          if (!ph) status <= nand_io_in;
          else if (op == OP_CACHE ? status[6] : status[5]) st <= S_DONE;
        end
        S_DONE: begin
          st <= S_IDLE;
          if (op == OP_PROG) sess <= 1'b0;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic unused_ok;
  assign unused_ok = poll_hit;

  assert_latch_excl_R2: assert property (@(posedge clk) disable iff (!rst_n) !(nand_cle && nand_ale));
  assert_we_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n) !nand_we_n |=> nand_we_n);
  assert_no_drive_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n) !nand_re_n |-> !nand_io_oe);
  assert_ce_on_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n) (!nand_we_n || !nand_re_n) |-> !nand_ce_n);
  assert_fail_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n) fail |-> done);
  assert_settle_blocks_rb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (nand_cle && !nand_we_n && (nand_io_out == 8'h10 || nand_io_out == 8'h15)) |=> ##1 nand_we_n && !nand_re_n == 1'b0);
endmodule

// File: tb/test_nand_prog_seq.sv
`timescale 1ns/1ps
module test_nand_prog_seq;
  localparam int SETTLE = 4;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [2:0] req_op = 0;
  logic [15:0] req_col = 0;
  logic [23:0] req_row = 0;
  logic [7:0] req_data = 0;
  logic ready, done, fail, nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
  logic [7:0] status, nand_io_out, nand_io_in;
  logic nand_rb;

  nand_prog_seq #(.SETTLE(SETTLE)) i_nand_prog_seq (.*);

  always #2 clk = !clk;

  int tests = 0, fails = 0;
  int log_n = 0;
  logic [1:0] log_k [0:63];
  logic [7:0] log_v [0:63];
  int exp_n = 0;
  logic [1:0] exp_k [0:63];
  logic [7:0] exp_v [0:63];

  logic prev_we = 1, prev_re = 1;
  int wb = 0, rbc = 0, arc = 0;
  logic rb_m = 1, model_fail = 0, early70 = 0, we_long = 0, ce_bad = 0, in_sess = 0;
  int t_rb = 6, t_arr = 20, reads = 0;

  assign nand_rb = rb_m;
  assign nand_io_in = {1'b1, rb_m, (arc == 0), 4'b0, model_fail};

  always @(negedge clk) begin
    if (rst_n) begin
      if (!prev_we && nand_we_n && log_n < 64) begin
        log_k[log_n] = nand_cle ? 2'd1 : nand_ale ? 2'd2 : 2'd0;
        log_v[log_n] = nand_io_out;
        log_n++;
        if (nand_cle && (nand_io_out == 8'h10 || nand_io_out == 8'h15)) begin
          wb = 2; arc = t_arr;
        end
        if (nand_cle && nand_io_out == 8'h70 && (wb > 0 || !rb_m)) early70 = 1;
      end
      if (!prev_we && !nand_we_n) we_long = 1;
      if (!nand_re_n) reads++;
      if (in_sess && nand_ce_n) ce_bad = 1;
      if (wb > 0) begin
        wb--;
        if (wb == 0) begin rb_m = 0; rbc = t_rb; end
      end else if (!rb_m) begin
        if (rbc > 0) rbc--; else rb_m = 1;
      end
      if (arc > 0) arc--;
    end
    prev_we = nand_we_n;
    prev_re = nand_re_n;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; tests++;
      $display("FAIL watchdog expired: got no completion, expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic expect_byte(input logic [1:0] k, input logic [7:0] v);
    exp_k[exp_n] = k; exp_v[exp_n] = v; exp_n++;
  endtask

  task automatic compare_log(input string req);
    check({req, " byte count"}, log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++)
      check($sformatf("%s byte %0d", req, i), {22'd0, log_k[i], log_v[i]}, {22'd0, exp_k[i], exp_v[i]});
    log_n = 0; exp_n = 0;
  endtask

  task automatic step(input logic [2:0] op, input logic [15:0] c, input logic [23:0] r,
                      input logic [7:0] d, output logic f, output logic [7:0] s);
    @(negedge clk);
    while (!ready) @(negedge clk);
    req_valid = 1; req_op = op; req_col = c; req_row = r; req_data = d;
    @(negedge clk);
    req_valid = 0;
    while (!done) @(negedge clk);
    f = fail; s = status;
  endtask

  task automatic t_reset();
    check("R1 ready", ready, 1);
    check("R1 ce_n", nand_ce_n, 1);
    check("R1 we_n/re_n", {nand_we_n, nand_re_n}, 2'b11);
    check("R1 cle/ale/oe/done", {nand_cle, nand_ale, nand_io_oe, done}, 4'b0);
  endtask

  task automatic t_page_program();
    logic f; logic [7:0] s;
    model_fail = 0; t_arr = 20; reads = 0;
    step(0, 16'h0123, 24'h0ABCDE, 0, f, s); in_sess = 1;
    step(1, 0, 0, 8'hA1, f, s);
    step(1, 0, 0, 8'hA2, f, s);
    step(2, 16'h0456, 0, 0, f, s);
    step(1, 0, 0, 8'hB1, f, s);
    step(2, 16'h0789, 0, 0, f, s);
    step(1, 0, 0, 8'hC1, f, s);
    step(3, 0, 0, 0, f, s);
    in_sess = 0;
    expect_byte(1, 8'h80); expect_byte(2, 8'h23); expect_byte(2, 8'h01);
    expect_byte(2, 8'hDE); expect_byte(2, 8'hBC); expect_byte(2, 8'h0A);
    expect_byte(0, 8'hA1); expect_byte(0, 8'hA2);
    expect_byte(1, 8'h85); expect_byte(2, 8'h56); expect_byte(2, 8'h04); expect_byte(0, 8'hB1);
    expect_byte(1, 8'h85); expect_byte(2, 8'h89); expect_byte(2, 8'h07); expect_byte(0, 8'hC1);
    expect_byte(1, 8'h10); expect_byte(1, 8'h70);
    compare_log("R2 R3 R4 R5 page sequence");
    check("R5 pass flag", f, 0);
    check("R5 array ready bit at done", s[5], 1);
    check("R5 repeated status reads", reads > 1, 1);
  endtask

  task automatic t_cache_chain();
    logic f; logic [7:0] s;
    model_fail = 0; t_arr = 60;
    step(0, 16'h0000, 24'h00003F, 0, f, s); in_sess = 1;
    step(1, 0, 0, 8'h5A, f, s);
    step(4, 0, 0, 0, f, s);
    check("R6 cache done without fail", f, 0);
    check("R6 cache ready set, array still busy", {s[6], s[5]}, 2'b10);
    model_fail = 1; t_arr = 20;
    step(0, 16'h0010, 24'h000040, 0, f, s);
    step(2, 16'h0020, 0, 0, f, s);
    step(1, 0, 0, 8'h6B, f, s);
    step(3, 0, 0, 0, f, s);
    in_sess = 0;
    check("R5 fail flag from status bit 0", f, 1);
    expect_byte(1, 8'h80); expect_byte(2, 8'h00); expect_byte(2, 8'h00);
    expect_byte(2, 8'h3F); expect_byte(2, 8'h00); expect_byte(2, 8'h00);
    expect_byte(0, 8'h5A); expect_byte(1, 8'h15); expect_byte(1, 8'h70);
    expect_byte(1, 8'h80); expect_byte(2, 8'h10); expect_byte(2, 8'h00);
    expect_byte(2, 8'h40); expect_byte(2, 8'h00); expect_byte(2, 8'h00);
    expect_byte(1, 8'h85); expect_byte(2, 8'h20); expect_byte(2, 8'h00);
    expect_byte(0, 8'h6B); expect_byte(1, 8'h10); expect_byte(1, 8'h70);
    compare_log("R6 cache chain across block");
  endtask

  task automatic t_ignore_busy();
    logic f; logic [7:0] s;
    model_fail = 0; t_arr = 20;
    step(0, 16'h0001, 24'h000100, 0, f, s); in_sess = 1;
    @(negedge clk);
    req_valid = 1; req_op = 3;
    @(negedge clk);
    req_valid = 0;
    repeat (3) @(negedge clk);
    req_valid = 1; req_op = 1; req_data = 8'hEE;
    repeat (3) @(negedge clk);
    req_valid = 0;
    while (!done) @(negedge clk);
    in_sess = 0;
    check("R10 no 0xEE byte, fail clear", fail, 0);
    expect_byte(1, 8'h10); expect_byte(1, 8'h70);
    log_n = (log_n >= 6) ? log_n - 6 : log_n;
    for (int i = 0; i < log_n; i++) begin
      log_k[i] = log_k[i + 6]; log_v[i] = log_v[i + 6];
    end
    compare_log("R10 busy request ignored");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_page_program();
    t_cache_chain();
    t_ignore_busy();
    check("R7 no status command before busy seen", early70, 0);
    check("R8 write strobe one cycle low", we_long, 0);
    check("R9 chip enable held in session", ce_bad, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule